// File: doc/BRIEF.md
# NAND Raw Page-Read Sequencer

This block performs the front half of a raw page read on an 8-bit NAND device, and it returns the first byte it reads. A one-cycle `start_i` pulse latches a row (page) number, a column offset and a mode bit. The mode bit picks two or three row-address cycles. The block then puts an opening command byte, the address bytes and a confirm command byte onto the bus. Each byte appears with the correct latch strobe and one write pulse. The block then waits for the device's ready line, pulses the read strobe and captures one byte.

The usual use is a bad-block probe. Software points the column at the first spare-area byte of a block's first page and compares the returned byte against the erased value. The result comes back as a one-cycle `done_o` pulse, and `byte_o` holds the byte until the next completion. The result has no back-pressure: it is a status pulse, and the caller must take it in the cycle it appears. If the device never reports ready, `timeout_o` pulses in place of `done_o`.

Top module: `nand_read_seq`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o, nand_cle_o and nand_ale_o are 0, nand_we_n_o and nand_re_n_o are 1, and byte_o is 8'h00.
- R2: Bus bytes go out in this order: 8'h00 with nand_cle_o=1, column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8 (all address bytes with nand_ale_o=1), and finally 8'h30 with nand_cle_o=1.
- R3: With two_row_i=0 at start, row bits 23:16 go out as a third row byte before the confirm byte, for 7 bytes in total. With two_row_i=1 that byte is left out, for 6 bytes.
- R4: Each byte stays on nand_dq_o for HOLD_CYC cycles. Within that hold, nand_we_n_o is low for exactly one cycle, the cycle at offset HOLD_CYC/2. nand_cle_o and nand_ale_o are never high together.
- R5: busy_o is high from the cycle after start_i is sampled until the cycle in which done_o or timeout_o is high, and it falls in that same cycle. A start_i pulse while busy_o is high is ignored and leaves the bus sequence unchanged.
- R6: After the confirm byte, nand_rdy_i is ignored for the first GUARD_CYC cycles. Once nand_rdy_i is seen high, nand_re_n_o is low for exactly HOLD_CYC cycles. The byte on nand_dq_i in the last of those cycles is the result.
- R7: done_o is a one-cycle pulse HOLD_CYC+1 cycles after nand_rdy_i rises (once the guard has passed). byte_o holds the captured byte until the next done_o.
- R8: If nand_rdy_i is not seen high within TMO_CYC wait cycles, timeout_o pulses HOLD_CYC-HOLD_CYC/2+TMO_CYC cycles after the confirm byte's write pulse. In that case there is no read strobe, no done_o, and byte_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a read |
| row_i | input | 24 | Page (row) number |
| col_i | input | 16 | Column offset inside the page |
| two_row_i | input | 1 | 1 selects two row-address cycles, 0 selects three |
| nand_dq_o | output | 8 | Command/address byte driven to the device |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Active-low write strobe |
| nand_re_n_o | output | 1 | Active-low read strobe |
| nand_dq_i | input | 8 | Data byte from the device |
| nand_rdy_i | input | 1 | Device ready (1) / busy (0) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: byte_o is valid |
| timeout_o | output | 1 | One-cycle pulse: ready never came |
| byte_o | output | 8 | Captured data byte |

## Verification
The first command byte is on the bus one cycle after start_i is sampled. Each byte's write pulse falls HOLD_CYC/2 cycles into its hold, and pulses are spaced exactly HOLD_CYC cycles apart. done_o is due HOLD_CYC+1 cycles after ready rises. timeout_o is due HOLD_CYC-HOLD_CYC/2+TMO_CYC cycles after the confirm write pulse. The bench stamps every strobe, ready edge and completion with a shared cycle counter, and it compares the differences against these formulas. The device model drives a junk byte while busy, so a read taken before ready returns the wrong value.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ROW_W  = 24;
  localparam int unsigned COL_W  = 16;

  localparam logic [BYTE_W-1:0] OP_OPEN    = 8'h00;
  localparam logic [BYTE_W-1:0] OP_CONFIRM = 8'h30;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_READ
  } nrs_state_e;

  // Slot order is bus order; the three-byte row path walks every slot.
  typedef enum logic [2:0] {
    SL_OPEN    = 3'd0,
    SL_COL_LO  = 3'd1,
    SL_COL_HI  = 3'd2,
    SL_ROW_LO  = 3'd3,
    SL_ROW_MID = 3'd4,
    SL_ROW_HI  = 3'd5,
    SL_CONFIRM = 3'd6
  } nrs_slot_e;
endpackage

// File: rtl/nrs_pace.sv
// Per-byte hold counter: counts 0..HOLD_CYC-1 while run is high.
module nrs_pace #(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last,
  output logic mid
);
  localparam int unsigned CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] MID_V  = CW'(HOLD_CYC / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (cnt_q == LAST_V) cnt_q <= '0;
    else                 cnt_q <= cnt_q + CW'(1);
  end

  assign last = run && (cnt_q == LAST_V);
  assign mid  = run && (cnt_q == MID_V);
endmodule

// File: rtl/nrs_wait_timer.sv
// Counts wait cycles: arms after the guard window, expires at the limit.
module nrs_wait_timer #(
  parameter int unsigned GUARD_CYC = 2,
  parameter int unsigned TMO_CYC   = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic armed,
  output logic expired
);
  localparam int unsigned TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] END_V   = TW'(TMO_CYC - 1);
  localparam logic [TW-1:0] GUARD_V = TW'(GUARD_CYC);

  logic [TW-1:0] wcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wcnt_q <= '0;
    else if (!run)            wcnt_q <= '0;
    else if (wcnt_q != END_V) wcnt_q <= wcnt_q + TW'(1);
  end

  assign armed   = run && (wcnt_q >= GUARD_V);
  assign expired = run && (wcnt_q == END_V);
endmodule

// File: rtl/nrs_byte_pick.sv
// Maps the current slot to the bus byte and its latch kind.
module nrs_byte_pick
  import nrs_pkg::*;
(
  input  nrs_slot_e               slot,
  input  logic [COL_W-1:0]        col,
  input  logic [ROW_W-1:0]        row,
  output logic [BYTE_W-1:0]       bus_byte,
  output logic                    is_cmd
);
  always_comb begin
    is_cmd   = 1'b0;
    bus_byte = '0;
    unique case (slot)
      SL_OPEN:    begin is_cmd = 1'b1; bus_byte = OP_OPEN; end
      SL_COL_LO:  bus_byte = col[7:0];
      SL_COL_HI:  bus_byte = col[15:8];
      SL_ROW_LO:  bus_byte = row[7:0];
      SL_ROW_MID: bus_byte = row[15:8];
      SL_ROW_HI:  bus_byte = row[23:16];
      SL_CONFIRM: begin is_cmd = 1'b1; bus_byte = OP_CONFIRM; end
      default:    bus_byte = '0;
    endcase
  end
endmodule

// File: rtl/nand_read_seq.sv
module nand_read_seq
  import nrs_pkg::*;
#(
  parameter int unsigned HOLD_CYC  = 4,
  parameter int unsigned GUARD_CYC = 2,
  parameter int unsigned TMO_CYC   = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [23:0] row_i,
  input  logic [15:0] col_i,
  input  logic        two_row_i,
  output logic [7:0]  nand_dq_o,
  output logic        nand_cle_o,
  output logic        nand_ale_o,
  output logic        nand_we_n_o,
  output logic        nand_re_n_o,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rdy_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        timeout_o,
  output logic [7:0]  byte_o
);
  nrs_state_e         state_q;
  nrs_slot_e          slot_q;
  nrs_slot_e          slot_nx;
  logic [ROW_W-1:0]   row_q;
  logic [COL_W-1:0]   col_q;
  logic               two_row_q;
  logic [BYTE_W-1:0]  byte_q;
  logic               done_q;
  logic               tmo_q;

  logic               pace_run, pace_last, pace_mid;
  logic               wait_run, wait_armed, wait_expired;
  logic [BYTE_W-1:0]  bus_byte;
  logic               bus_is_cmd;

  assign pace_run = (state_q == ST_SEND) || (state_q == ST_READ);
  assign wait_run = (state_q == ST_WAIT);

  nrs_pace #(.HOLD_CYC(HOLD_CYC)) u_pace (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (pace_run),
    .last (pace_last),
    .mid  (pace_mid)
  );

  nrs_wait_timer #(.GUARD_CYC(GUARD_CYC), .TMO_CYC(TMO_CYC)) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (wait_run),
    .armed  (wait_armed),
    .expired(wait_expired)
  );

  nrs_byte_pick u_pick (
    .slot    (slot_q),
    .col     (col_q),
    .row     (row_q),
    .bus_byte(bus_byte),
    .is_cmd  (bus_is_cmd)
  );

  // Short row mode jumps from the middle row byte straight to confirm.
  always_comb begin
    if (slot_q == SL_ROW_MID && two_row_q) slot_nx = SL_CONFIRM;
    else                                   slot_nx = nrs_slot_e'(slot_q + 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      slot_q    <= SL_OPEN;
      row_q     <= '0;
      col_q     <= '0;
      two_row_q <= 1'b0;
      byte_q    <= '0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            row_q     <= row_i;
            col_q     <= col_i;
            two_row_q <= two_row_i;
            slot_q    <= SL_OPEN;
            state_q   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (pace_last) begin
            if (slot_q == SL_CONFIRM) state_q <= ST_WAIT;
            else                      slot_q  <= slot_nx;
          end
        end
        ST_WAIT: begin
          // Ready wins over expiry when both land in one cycle.
          if (wait_armed && nand_rdy_i) begin
            state_q <= ST_READ;
          end else if (wait_expired) begin
            tmo_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_READ: begin
          if (pace_last) begin
            byte_q  <= nand_dq_i;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign nand_dq_o   = (state_q == ST_SEND) ? bus_byte : '0;
  assign nand_cle_o  = (state_q == ST_SEND) && bus_is_cmd;
  assign nand_ale_o  = (state_q == ST_SEND) && !bus_is_cmd;
  assign nand_we_n_o = !((state_q == ST_SEND) && pace_mid);
  assign nand_re_n_o = (state_q != ST_READ);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;
  assign byte_o      = byte_q;
endmodule

// File: rtl/nrs_check.sv
module nrs_check #(
  parameter int unsigned HOLD_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] dq,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic       re_n,
  input logic       rdy,
  input logic       busy,
  input logic       done,
  input logic       timeout
);
  // R4: never both latches at once
  a_r4_one_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cle, ale}));

  // R4: a write pulse always sits inside a latch window
  a_r4_strobe_in_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (cle || ale));

  // R4: the byte does not change at the write pulse
  a_r4_dq_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (HOLD_CYC > 1 && !we_n) |-> $stable(dq));

  // R4: the write pulse lasts a single cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (HOLD_CYC > 1 && !we_n) |=> we_n);

  // R6: the read strobe starts only after ready was seen
  a_r6_read_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(re_n) |-> $past(rdy));

  // R5: any bus activity happens while busy
  a_r5_busy_covers_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (cle || ale || !re_n) |-> busy);

  // R5: completion ends busy
  a_r5_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !busy);

  // R8: done and timeout are exclusive
  a_r8_excl_result: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
endmodule

bind nand_read_seq nrs_check #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .dq     (nand_dq_o),
  .cle    (nand_cle_o),
  .ale    (nand_ale_o),
  .we_n   (nand_we_n_o),
  .re_n   (nand_re_n_o),
  .rdy    (nand_rdy_i),
  .busy   (busy_o),
  .done   (done_o),
  .timeout(timeout_o)
);

// File: tb/nand_read_seq_tb.sv
`timescale 1ns/1ps
module nand_read_seq_tb;
  localparam int HOLD  = 4;
  localparam int GUARD = 2;
  localparam int TMO   = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] row_i = '0;
  logic [15:0] col_i = '0;
  logic        two_row_i = 1'b0;
  logic [7:0]  nand_dq_o;
  logic        nand_cle_o, nand_ale_o, nand_we_n_o, nand_re_n_o;
  logic [7:0]  nand_dq_i;
  logic        nand_rdy_i;
  logic        busy_o, done_o, timeout_o;
  logic [7:0]  byte_o;

  always #5 clk = ~clk;

  nand_read_seq #(.HOLD_CYC(HOLD), .GUARD_CYC(GUARD), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .row_i(row_i), .col_i(col_i),
    .two_row_i(two_row_i), .nand_dq_o(nand_dq_o), .nand_cle_o(nand_cle_o),
    .nand_ale_o(nand_ale_o), .nand_we_n_o(nand_we_n_o), .nand_re_n_o(nand_re_n_o),
    .nand_dq_i(nand_dq_i), .nand_rdy_i(nand_rdy_i), .busy_o(busy_o),
    .done_o(done_o), .timeout_o(timeout_o), .byte_o(byte_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Device model state
  int        cyc = 0;
  int        cfg_busy = 0;
  logic [7:0] cfg_data = 8'h00;
  int        left = 0;
  logic      rdy_m = 1'b1;
  int        ncap = 0;
  logic [7:0] cap_b [16];
  int        cap_k [16];
  int        cap_t [16];
  int        strobe_t = 0, rise_t = 0, done_t = 0, tmo_t = 0;
  int        ndone = 0, ntmo = 0, nre = 0;

  assign nand_rdy_i = rdy_m;
  assign nand_dq_i  = rdy_m ? cfg_data : 8'hA5;

  always @(negedge clk) begin
    cyc++;
    if (!nand_we_n_o) begin
      if (ncap < 16) begin
        cap_b[ncap] = nand_dq_o;
        cap_k[ncap] = nand_cle_o ? 1 : (nand_ale_o ? 2 : 0);
        cap_t[ncap] = cyc;
      end
      ncap++;
      if (nand_cle_o && nand_dq_o == 8'h30) begin
        strobe_t = cyc;
        if (cfg_busy > 0) begin rdy_m = 1'b0; left = cfg_busy; end
      end
    end else if (left > 0) begin
      left--;
      if (left == 0) begin rdy_m = 1'b1; rise_t = cyc; end
    end
    if (!nand_re_n_o) nre++;
    if (done_o)    begin ndone++; done_t = cyc; end
    if (timeout_o) begin ntmo++;  tmo_t  = cyc; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_byte(input int i, input logic [23:0] row,
                                          input logic [15:0] col, input bit two);
    case (i)
      0: return {2'd1, 8'h00};
      1: return {2'd2, col[7:0]};
      2: return {2'd2, col[15:8]};
      3: return {2'd2, row[7:0]};
      4: return {2'd2, row[15:8]};
      5: return two ? {2'd1, 8'h30} : {2'd2, row[23:16]};
      default: return {2'd1, 8'h30};
    endcase
  endfunction

  task automatic do_read(input logic [23:0] row, input logic [15:0] col, input bit two,
                         input int busy_len, input logic [7:0] data, input bit inject);
    bit  expect_tmo;
    bit  gap;
    int  nexp;
    logic [7:0] prev_byte;
    expect_tmo = (busy_len > TMO + GUARD + HOLD);
    prev_byte  = byte_o;
    @(negedge clk); #1;
    cfg_busy = busy_len; cfg_data = data;
    ncap = 0; ndone = 0; ntmo = 0; nre = 0; gap = 0;
    row_i = row; col_i = col; two_row_i = two; start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      if (ndone != 0 || ntmo != 0) break;
      if (!busy_o) gap = 1;
      if (inject && k == 10) begin start_i = 1'b1; row_i = ~row; col_i = ~col; two_row_i = ~two; end
      if (inject && k == 11) start_i = 1'b0;
      @(negedge clk); #1;
    end
    check(!busy_o, "R5 busy low at completion", busy_o, 0);
    check(!gap, "R5 busy held until completion", gap, 0);
    repeat (8) begin @(negedge clk); #1; end
    nexp = two ? 6 : 7;
    check(ncap == nexp, "R3 byte count", ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++) begin
      logic [9:0] e;
      e = exp_byte(i, row, col, two);
      check({cap_k[i][1:0], cap_b[i]} == e, "R2 byte/latch", {cap_k[i][1:0], cap_b[i]}, e);
      if (i > 0) check(cap_t[i] - cap_t[i-1] == HOLD, "R4 strobe spacing",
                       cap_t[i] - cap_t[i-1], HOLD);
    end
    if (!expect_tmo) begin
      check(ndone == 1 && ntmo == 0, "R7 single done", ndone, 1);
      check(byte_o == data, "R6 captured byte", byte_o, data);
      check(nre == HOLD, "R6 read strobe length", nre, HOLD);
      if (busy_len >= 6)
        check(done_t - rise_t == HOLD + 1, "R7 done latency", done_t - rise_t, HOLD + 1);
    end else begin
      check(ntmo == 1 && ndone == 0, "R8 single timeout", ntmo, 1);
      check(nre == 0, "R8 no read strobe", nre, 0);
      check(tmo_t - strobe_t == HOLD - HOLD/2 + TMO, "R8 timeout latency",
            tmo_t - strobe_t, HOLD - HOLD/2 + TMO);
      while (!rdy_m) begin @(negedge clk); #1; end
      repeat (4) begin @(negedge clk); #1; end
      check(ndone == 0, "R8 late ready gives no done", ndone, 0);
      check(byte_o == prev_byte, "R8 byte_o kept", byte_o, prev_byte);
    end
    check(byte_o == (expect_tmo ? prev_byte : data), "R7 byte_o held", byte_o,
          expect_tmo ? prev_byte : data);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed1234);
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(!busy_o && !done_o && !timeout_o, "R1 status idle", {busy_o, done_o, timeout_o}, 0);
    check(!nand_cle_o && !nand_ale_o && nand_we_n_o && nand_re_n_o, "R1 bus idle",
          {nand_cle_o, nand_ale_o, nand_we_n_o, nand_re_n_o}, 4'b0011);
    check(byte_o == 8'h00, "R1 byte_o", byte_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_read(24'hABCDEF, 16'h1234, 1'b0, 8, 8'h5A, 1'b0);    // R3 three row bytes
    do_read(24'hABCDEF, 16'h1234, 1'b1, 12, 8'hC3, 1'b0);   // R3 two row bytes
    do_read(24'h000001, 16'h0800, 1'b0, 0, 8'hFF, 1'b0);    // R6 ready never low
    do_read(24'h00FF00, 16'hFFFF, 1'b1, 1, 8'h00, 1'b0);    // R6 ready inside guard
    do_read(24'h123456, 16'h0840, 1'b0, 20, 8'h3C, 1'b1);   // R5 start ignored
    do_read(24'h0F0F0F, 16'h0001, 1'b0, TMO + 80, 8'h77, 1'b0); // R8 timeout
    do_read(24'h0F0F0F, 16'h0001, 1'b1, 7, 8'h81, 1'b0);    // recovers after timeout

    for (int n = 0; n < 24; n++) begin
      logic [23:0] r;
      logic [15:0] c;
      r = 24'($urandom);
      c = 16'($urandom);
      do_read(r, c, 1'($urandom % 2), int'($urandom % 40), 8'($urandom), 1'($urandom % 4 == 0));
    end
    report();
  end
endmodule